// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns a small group of external interrupt pins into interrupt requests for a CPU core. Every pin passes through a synchroniser clocked by the CPU clock. A two-bit sense code, held in a byte-wide read/write control register, selects how each pin raises a request. The choices are low-level sensing, falling-edge sensing and rising-edge sensing. One code value is reserved.

In level mode the request is not stored: it follows the synchronised pin and drops as soon as the pin returns high. In the two edge modes a detected edge sets a sticky pending flag, and the flag stays set until a per-pin acknowledge pulse clears it. A request leaves the block only when the pin's mask bit and the global interrupt enable are both high. The sense code is decoded combinationally in every cycle. A code change therefore acts at once, including the spurious request it can cause when the pin is not masked. During a short warm-up after reset the detectors follow the pins without reporting, so a pin that sits high or low through reset raises no false edge.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the control register reads 0x00, no pending flag is set and every request output is 0.
- R2: A write (wr_en high at a rising clock edge) stores wr_data, and rd_data shows it from that edge on. Pin k (pin_in[k], k = 0 is the lowest) takes its sense code from register bits [2k+1:2k].
- R3: irq_out[k] can be 1 only when mask_in[k] and gie_in are both 1. Masking gates only the output: a pending flag is still set while its pin is masked.
- R4: Code 00 is low-level sensing. irq_out[k] is 1 while the synchronised pin is low, two clock edges after the pin changes, and it falls again two edges after the pin goes high (not latched).
- R5: Code 10 is falling-edge sensing. A high-to-low pin change sets the pending flag, and the request appears three clock edges after the change. A low pulse that lasts two clock periods is always caught and remains pending after the pin returns high.
- R6: Code 11 is rising-edge sensing. A low-to-high change sets the pending flag, and the request appears on the third clock edge after the change and not before it.
- R7: A one-cycle ack_in[k] clears pin k's pending flag. When an acknowledge and a new edge meet at the same clock edge, the flag is set.
- R8: Code 01 is reserved. It gives no request, and the pending flag keeps its value (an acknowledge is ignored). Pending state kept under code 01 shows again once an edge code is restored.
- R9: A pin held steady high or low through reset and the warm-up that follows raises no edge request. No request of any kind is given during the warm-up of SYNC_STAGES+1 cycles.
- R10: The sense code is re-evaluated in the cycle after it is written. Switching an unmasked pin that is held low from an edge code to level mode raises a request on that next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 2*NUM_PINS | Control register write data |
| rd_data | output | 2*NUM_PINS | Control register contents |
| pin_in | input | NUM_PINS | External interrupt pins, asynchronous |
| mask_in | input | NUM_PINS | Per-pin interrupt mask, 1 enables |
| gie_in | input | 1 | Global interrupt enable |
| ack_in | input | NUM_PINS | Per-pin pending acknowledge pulse |
| irq_out | output | NUM_PINS | Per-pin interrupt request |

## Verification
The bench builds the block with its default values, four pins and a two-stage synchroniser. These make the control register one byte wide, with the pair for pin 0 in bits 1:0 and the pair for pin 3 in bits 7:6. They also fix the level latency at two edges and the edge latency at three, so directed checks can sample the exact cycle in which a request first appears. The same short pipeline lets random pin toggling produce two-cycle pulses, acknowledges that meet an edge in the same cycle, and code rewrites on live pins, so random stimulus reaches each of these often.

// File: rtl/ext_irq_sense_pkg.sv
package ext_irq_sense_pkg;

   localparam int unsigned CODE_W = 2;

   typedef enum logic [CODE_W-1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_RSVD = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_e;

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/eis_warmup.sv
module eis_warmup #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic ready_o
);

   localparam int unsigned LIMIT = STAGES + 1;
   localparam int unsigned CNT_W = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (cnt_q != LIMIT_V) cnt_q <= cnt_q + 1'b1;
   end

   assign ready_o = (cnt_q == LIMIT_V);

endmodule

// File: rtl/eis_ctrl_reg.sv
module eis_ctrl_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [WIDTH-1:0] wr_data_i,
   output logic [WIDTH-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_o <= '0;
      else if (wr_en_i) q_o <= wr_data_i;
   end

endmodule

// File: rtl/eis_pin_sense.sv
module eis_pin_sense
   import ext_irq_sense_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ready_i,
   input  logic              level_i,
   input  logic              ack_i,
   input  logic              enable_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              irq_o,
   output logic              pend_o,
   output logic              prev_o
);

   logic   prev_q;
   logic   pend_q;
   logic   pend_d;
   logic   edge_hit;
   logic   raw_req;
   sense_e mode;

   assign mode = sense_e'(code_i);

   // previous sample tracks the synchroniser also during warm-up (preset)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_i;
   end

   always_comb begin
      edge_hit = 1'b0;
      raw_req  = 1'b0;
      unique case (mode)
         SENSE_LOW:  raw_req = ready_i & ~level_i;
         SENSE_RSVD: raw_req = 1'b0;
         SENSE_FALL: begin
            edge_hit = ready_i & prev_q & ~level_i;
            raw_req  = pend_q;
         end
         SENSE_RISE: begin
            edge_hit = ready_i & ~prev_q & level_i;
            raw_req  = pend_q;
         end
         default: raw_req = 1'b0;
      endcase
   end

   always_comb begin
      pend_d = pend_q;
      if (mode != SENSE_RSVD) begin
         if (edge_hit)   pend_d = 1'b1;
         else if (ack_i) pend_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_d;
   end

   assign irq_o  = raw_req & enable_i;
   assign pend_o = pend_q;
   assign prev_o = prev_q;

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
   import ext_irq_sense_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned REG_W      = NUM_PINS * CODE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [REG_W-1:0]    wr_data,
   output logic [REG_W-1:0]    rd_data,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [NUM_PINS-1:0] mask_in,
   input  logic                gie_in,
   input  logic [NUM_PINS-1:0] ack_in,
   output logic [NUM_PINS-1:0] irq_out
);

   if (NUM_PINS < 1 || NUM_PINS > 16) begin : g_chk_pins
      $error("ext_irq_sense: NUM_PINS must be within 1..16");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_chk_sync
      $error("ext_irq_sense: SYNC_STAGES must be within 2..4");
   end

   logic [REG_W-1:0]    ctrl_q;
   logic [NUM_PINS-1:0] pin_sync;
   logic [NUM_PINS-1:0] prev_q;
   logic [NUM_PINS-1:0] pend_q;
   logic                warm_ready;

   eis_ctrl_reg #(.WIDTH(REG_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_data_i (wr_data),
      .q_o       (ctrl_q)
   );

   eis_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_in),
      .q_o   (pin_sync)
   );

   eis_warmup #(.STAGES(SYNC_STAGES)) u_warm (
      .clk     (clk),
      .rst_n   (rst_n),
      .ready_o (warm_ready)
   );

   for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
      eis_pin_sense u_pin (
         .clk      (clk),
         .rst_n    (rst_n),
         .ready_i  (warm_ready),
         .level_i  (pin_sync[k]),
         .ack_i    (ack_in[k]),
         .enable_i (mask_in[k] & gie_in),
         .code_i   (ctrl_q[k*CODE_W +: CODE_W]),
         .irq_o    (irq_out[k]),
         .pend_o   (pend_q[k]),
         .prev_o   (prev_q[k])
      );
   end

   assign rd_data = ctrl_q;

endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
   parameter int unsigned NUM_PINS = 4,
   parameter int unsigned REG_W    = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [REG_W-1:0]    wr_data,
   input logic [REG_W-1:0]    rd_data,
   input logic [NUM_PINS-1:0] mask_in,
   input logic                gie_in,
   input logic [NUM_PINS-1:0] ack_in,
   input logic [NUM_PINS-1:0] irq_out,
   input logic                ready,
   input logic [NUM_PINS-1:0] cur,
   input logic [NUM_PINS-1:0] prev,
   input logic [NUM_PINS-1:0] pend
);

   AST_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data == $past(wr_data)); // R2

   AST_GIE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_in |-> irq_out == '0); // R3

   AST_WARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> irq_out == '0); // R9

   for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
      AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
         !mask_in[k] |-> !irq_out[k]); // R3

      AST_LEVEL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
         (ready && rd_data[2*k +: 2] == 2'b00 && mask_in[k] && gie_in && !cur[k])
         |-> irq_out[k]); // R4

      AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         (ready && rd_data[2*k +: 2] == 2'b11 && !prev[k] && cur[k])
         |=> pend[k]); // R7

      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_data[2*k +: 2] == 2'b10 && ack_in[k] && !(ready && prev[k] && !cur[k]))
         |=> !pend[k]); // R7

      AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
         rd_data[2*k +: 2] == 2'b01 |-> !irq_out[k]); // R8

      AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         rd_data[2*k +: 2] == 2'b01 |=> pend[k] == $past(pend[k])); // R8
   end

endmodule

bind ext_irq_sense ext_irq_sense_chk #(.NUM_PINS(NUM_PINS), .REG_W(REG_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .mask_in (mask_in),
   .gie_in  (gie_in),
   .ack_in  (ack_in),
   .irq_out (irq_out),
   .ready   (warm_ready),
   .cur     (pin_sync),
   .prev    (prev_q),
   .pend    (pend_q)
);

// File: tb/sim_ext_irq_sense.sv
module sim_ext_irq_sense;

   localparam int NP = 4;
   localparam int RW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [RW-1:0] wr_data = '0;
   logic [RW-1:0] rd_data;
   logic [NP-1:0] pin_in = '1;
   logic [NP-1:0] mask_in = '0;
   logic          gie_in = 1'b0;
   logic [NP-1:0] ack_in = '0;
   logic [NP-1:0] irq_out;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   ext_irq_sense u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .pin_in(pin_in), .mask_in(mask_in), .gie_in(gie_in), .ack_in(ack_in),
      .irq_out(irq_out)
   );

   // behavioural model written from the requirements
   logic [RW-1:0] m_reg;
   logic [NP-1:0] m_s1, m_s2, m_prev, m_pend;
   int            m_cnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_reg <= '0; m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_pend <= '0; m_cnt <= 0;
      end else begin
         if (wr_en) m_reg <= wr_data;
         m_s1   <= pin_in;
         m_s2   <= m_s1;
         m_prev <= m_s2;
         if (m_cnt < 3) m_cnt <= m_cnt + 1;
         for (int k = 0; k < NP; k++) begin
            logic [1:0] c;
            logic       hit;
            c   = m_reg[2*k +: 2];
            hit = (m_cnt == 3) && ((c == 2'b10 && m_prev[k] && !m_s2[k]) ||
                                   (c == 2'b11 && !m_prev[k] && m_s2[k]));
            if (c != 2'b01) begin
               if (hit)            m_pend[k] <= 1'b1;
               else if (ack_in[k]) m_pend[k] <= 1'b0;
            end
         end
      end
   end

   function automatic logic [NP-1:0] exp_irq();
      logic [NP-1:0] r;
      r = '0;
      for (int k = 0; k < NP; k++) begin
         if (mask_in[k] && gie_in) begin
            case (m_reg[2*k +: 2])
               2'b00:   r[k] = (m_cnt == 3) && !m_s2[k];
               2'b01:   r[k] = 1'b0;
               default: r[k] = m_pend[k];
            endcase
         end
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_irq(input logic [NP-1:0] e, input string tag);
      chk(irq_out === e, tag, 32'(irq_out), 32'(e));
   endtask

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [RW-1:0] v);
      wr_en = 1'b1; wr_data = v;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic ack(input logic [NP-1:0] m);
      ack_in = m;
      tick();
      ack_in = '0;
   endtask

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      pin_in = '1;
      tick(3);
      chk(rd_data === 8'h00, "R1 reg reset", 32'(rd_data), 0);
      chk_irq('0, "R1 irq reset");
      rst_n = 1'b1;

      // R9: pins steady high through reset, rising and falling codes
      mask_in = '1; gie_in = 1'b1;
      wr(8'hFF);
      tick(6);
      chk_irq('0, "R9 no false rising");
      wr(8'hAA);
      tick(4);
      chk_irq('0, "R9 no false falling");

      // R2: write and read back
      wr(8'hA5);
      chk(rd_data === 8'hA5, "R2 readback A5", 32'(rd_data), 32'hA5);
      wr(8'h00);
      chk(rd_data === 8'h00, "R2 readback 00", 32'(rd_data), 0);

      // R4: level mode on pin 2, two-edge latency, not latched
      pin_in = 4'b1011;
      tick();
      chk_irq('0, "R4 level before latency");
      tick();
      chk_irq(4'b0100, "R4 level asserted");
      pin_in = 4'b1111;
      tick(2);
      chk_irq('0, "R4 level follows pin");
      pin_in = 4'b1011;
      tick(3);

      // R3: gating
      gie_in = 1'b0; tick();
      chk_irq('0, "R3 gie low");
      gie_in = 1'b1; mask_in = 4'b1011; tick();
      chk_irq('0, "R3 mask low");
      mask_in = '1; tick();
      chk_irq(4'b0100, "R3 both set");

      // R5: two-cycle low pulse on pin 1, falling code (bits 3:2 = 10)
      pin_in = 4'b1111; tick(3);
      wr(8'h08);
      tick(2);
      chk_irq('0, "R5 idle");
      pin_in = 4'b1101;
      tick(2);
      chk_irq('0, "R5 before latency");
      pin_in = 4'b1111;
      tick();
      chk_irq(4'b0010, "R5 pulse caught");
      tick(3);
      chk_irq(4'b0010, "R5 sticky");

      // R7: acknowledge clears
      ack(4'b0010);
      chk_irq('0, "R7 ack clears");

      // R7: edge and acknowledge at the same edge
      pin_in = 4'b1101;
      tick(2);
      ack_in = 4'b0010;
      tick();
      ack_in = '0;
      chk_irq(4'b0010, "R7 edge wins over ack");

      // R8: reserved code holds pending, ignores ack
      wr(8'h04);
      chk_irq('0, "R8 reserved silent");
      pin_in = 4'b1111;
      tick(2);
      ack(4'b0010);
      chk_irq('0, "R8 reserved silent after ack");
      wr(8'h08);
      chk_irq(4'b0010, "R8 pending kept");
      ack(4'b0010);
      chk_irq('0, "R8 cleared in edge mode");

      // R10: pin 3 low under rising code, switch to level
      wr(8'hC0);
      pin_in = 4'b0111;
      tick(4);
      chk_irq('0, "R10 no rising edge");
      wr(8'h00);
      chk_irq(4'b1000, "R10 code change re-evaluated");

      // R6: rising on pin 0, exact latency
      wr(8'h03);
      pin_in = 4'b0110;
      tick(4);
      chk_irq(4'b1000, "R6 idle low");
      pin_in = 4'b0111;
      tick(2);
      chk_irq(4'b1000, "R6 before third edge");
      tick();
      chk_irq(4'b1001, "R6 rising caught");

      // random phase against the model
      rst_n = 1'b0;
      ack_in = '0; wr_en = 1'b0;
      tick(2);
      rst_n = 1'b1;
      void'($urandom(32'h1234_5678));
      for (int i = 0; i < 4000; i++) begin
         chk_irq(exp_irq(), "R4 R5 R6 R7 R8 R9 R10 random");
         chk(rd_data === m_reg, "R2 random readback", 32'(rd_data), 32'(m_reg));
         for (int k = 0; k < NP; k++)
            if ($urandom_range(3) == 0) pin_in[k] = ~pin_in[k];
         if ($urandom_range(15) == 0) mask_in = 4'($urandom);
         gie_in  = ($urandom_range(9) != 0);
         for (int k = 0; k < NP; k++) ack_in[k] = ($urandom_range(7) == 0);
         wr_en   = ($urandom_range(15) == 0);
         wr_data = 8'($urandom);
         tick();
      end
      finish_run();
   end

endmodule